// File: doc/BRIEF.md
# Edge/Level Interrupt Delivery Controller

This block turns raw interrupt pin levels into delivery messages for an interrupt router. Each pin has an entry that arrives already decoded from the register block: input polarity, trigger mode (edge or level), mask, vector, destination, destination mode and delivery mode. The block samples every pin each cycle and keeps a pending bit per pin. Level-triggered pins also have an in-service flag, which is set when a message for the pin is sent. Edge-triggered pins have a one-deep request latch.

Pins that are ready to deliver are served lowest index first. The chosen request goes into a single output register that is held until the receiver accepts it over a valid/ready handshake. An end-of-interrupt input carries a vector and clears the in-service flag of every level-triggered pin whose vector matches. If such a pin is still asserted and unmasked, it is delivered again. Pin 0 is special: it is always sent in physical destination mode to a fixed boot-processor ID. A per-pin pulse reports requests that were merged into an earlier one instead of producing a new message.

Top module: `idc_delivery_ctrl`

## Requirements
- R1: The effective level of a pin is its raw level XOR its polarity bit. With polarity 1, a falling raw level is treated as a rising request.
- R2: An effective level of 0 clears the pin's pending bit. A level-triggered pin whose level is low when its in-service flag is cleared is not delivered.
- R3: An edge-triggered pin produces exactly one message for each 0-to-1 change of its effective level. Holding the level high produces no further message.
- R4: A level-triggered pin is delivered only while its in-service flag is clear. Sending its message sets the flag, and a new rising level while the flag is set produces no message.
- R5: A masked pin never delivers. An edge that rises while the pin is masked is discarded and is not delivered after a later unmask.
- R6: An end-of-interrupt whose vector equals a level pin's vector clears that pin's in-service flag. The pin is re-delivered if it is still asserted and unmasked. A non-matching vector has no effect.
- R7: A message carries the pin's vector, destination, destination mode (1 = logical), trigger mode (1 = level) and 3-bit delivery mode. The level-asserted output is always 1 and the 2-bit shorthand output is always 0.
- R8: A message for pin 0 always has destination BOOT_ID and physical destination mode (0), whatever pin 0's entry holds.
- R9: When several pins are ready, the lowest index is sent first. A message held with valid high and ready low keeps all its fields unchanged until it is accepted.
- R10: `coalesced[i]` pulses for one cycle, one cycle after a request on unmasked pin i rises while it cannot be sent as a new message. For a level pin this means its in-service flag is set; for an edge pin it means an earlier edge is still waiting.
- R11: Unmasking a level-triggered pin whose pending bit is set and whose in-service flag is clear delivers it without a new pin edge.
- R12: After reset, `msg_valid` and `coalesced` are 0 and no pin is pending or in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_level | input | NPINS | Raw interrupt pin levels |
| cfg_polarity | input | NPINS | 1 inverts the pin level |
| cfg_level_trig | input | NPINS | 1 = level-triggered, 0 = edge-triggered |
| cfg_mask | input | NPINS | 1 blocks delivery |
| cfg_logical | input | NPINS | Destination mode, 1 = logical |
| cfg_vector | input | NPINS*VEC_W | Vector per pin, pin i at bits [i*VEC_W +: VEC_W] |
| cfg_dest | input | NPINS*DEST_W | Destination ID per pin, pin i at bits [i*DEST_W +: DEST_W] |
| cfg_dmode | input | NPINS*3 | Delivery mode per pin, pin i at bits [i*3 +: 3] |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | VEC_W | Vector being retired |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_pin | output | PIN_W | Source pin of the message |
| msg_vector | output | VEC_W | Vector |
| msg_dest | output | DEST_W | Destination ID |
| msg_logical | output | 1 | Destination mode |
| msg_level_trig | output | 1 | Trigger mode |
| msg_dmode | output | 3 | Delivery mode |
| msg_assert | output | 1 | Level-asserted flag, always 1 |
| msg_shorthand | output | 2 | Shorthand, always 0 |
| coalesced | output | NPINS | Per-pin merged-request pulse |

## Verification
A wrong in-service flag shows up at the ports in one of two ways. If the flag is stuck set, a level pin is never re-delivered after its end-of-interrupt. If the flag is stuck clear, the pin produces a second message within two cycles instead of a coalesced pulse. A lost or repeated edge latch shows up as a wrong per-pin message count. Wrong arbitration or a broken hold stage shows up as a changed `msg_pin` or message field while the message is stalled. The reference model compares every output on every cycle, so any such difference is reported within one cycle of the point where it becomes visible.

// File: rtl/idc_pkg.sv
// Shared constants for the interrupt delivery controller.
package idc_pkg;
    localparam int DMODE_W = 3;
    localparam int SHORT_W = 2;
    typedef logic [DMODE_W-1:0] dmode_t;
endpackage

// File: rtl/idc_pin_track.sv
// Per-pin request tracker.
// Applies polarity, keeps the pending bit, the edge request latch and the
// level in-service flag, and reports merged requests.
// Assumes `load` is high only in the cycle its message enters the output register.
module idc_pin_track (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic pol,
    input  logic lvl_trig,
    input  logic mask,
    input  logic load,
    input  logic eoi_hit,
    output logic eligible,
    output logic coal_q,
    output logic rirr_q
);
    logic pend_q, want_q;
    logic eff, rise, want_n, rirr_n, coal_n;

    // effective level and its rising change against the pending bit
    assign eff  = raw ^ pol;
    assign rise = eff & ~pend_q;

    // next-state terms for latch, in-service flag and merge report
    always_comb begin
        want_n = ~lvl_trig & ~mask & ((want_q & ~load) | rise);
        rirr_n = lvl_trig & (load | (rirr_q & ~eoi_hit));
        coal_n = ~mask & rise & (lvl_trig ? rirr_q : (want_q & ~load));
    end

    // ready to be granted this cycle
    assign eligible = ~mask & (lvl_trig ? (pend_q & ~rirr_q) : want_q);

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            want_q <= 1'b0;
            rirr_q <= 1'b0;
            coal_q <= 1'b0;
        end else begin
            pend_q <= eff;
            want_q <= want_n;
            rirr_q <= rirr_n;
            coal_q <= coal_n;
        end
    end
endmodule

// File: rtl/idc_prio_pick.sv
// Fixed-priority picker: the lowest set request bit wins.
// Assumes N >= 2.
module idc_prio_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    // isolate the lowest set bit
    assign gnt = req & (~req + N'(1));
    assign any = |req;

    // encode the winner; the downward scan leaves the lowest index in idx
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/idc_msg_reg.sv
// One-entry output holding register with a valid/ready handshake.
// Assumes `take` is asserted only when the slot is empty or being accepted.
module idc_msg_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic         ready,
    input  logic [W-1:0] din,
    output logic         valid,
    output logic [W-1:0] dout
);
    // hold, load or drain the message
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            dout  <= '0;
        end else if (take) begin
            valid <= 1'b1;
            dout  <= din;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/idc_delivery_ctrl.sv
// Edge/level interrupt delivery controller top.
// Tracks every pin, picks the lowest ready pin, builds its message
// (with the pin-0 boot-processor override) and holds it until accepted.
// Assumes the entry fields are stable register outputs from the table block.
module idc_delivery_ctrl
    import idc_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int VEC_W  = 8,
    parameter int DEST_W = 8,
    parameter logic [DEST_W-1:0] BOOT_ID = '0,
    localparam int PIN_W = $clog2(NPINS),
    localparam int PAY_W = PIN_W + VEC_W + DEST_W + 2 + DMODE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPINS-1:0]         pin_level,
    input  logic [NPINS-1:0]         cfg_polarity,
    input  logic [NPINS-1:0]         cfg_level_trig,
    input  logic [NPINS-1:0]         cfg_mask,
    input  logic [NPINS-1:0]         cfg_logical,
    input  logic [NPINS*VEC_W-1:0]   cfg_vector,
    input  logic [NPINS*DEST_W-1:0]  cfg_dest,
    input  logic [NPINS*DMODE_W-1:0] cfg_dmode,
    input  logic                     eoi_valid,
    input  logic [VEC_W-1:0]         eoi_vector,
    output logic                     msg_valid,
    input  logic                     msg_ready,
    output logic [PIN_W-1:0]         msg_pin,
    output logic [VEC_W-1:0]         msg_vector,
    output logic [DEST_W-1:0]        msg_dest,
    output logic                     msg_logical,
    output logic                     msg_level_trig,
    output logic [DMODE_W-1:0]       msg_dmode,
    output logic                     msg_assert,
    output logic [SHORT_W-1:0]       msg_shorthand,
    output logic [NPINS-1:0]         coalesced
);
    logic [NPINS-1:0] elig_vec, gnt_vec, load_vec, rirr_vec, eoi_hit;
    logic [PIN_W-1:0] sel_idx;
    logic             any_req, take, is_p0;
    logic [DEST_W-1:0] sel_dest;
    logic             sel_logical;
    logic [PAY_W-1:0] pay_d, pay_q;

    // one tracker per pin, with its end-of-interrupt vector match
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        assign eoi_hit[g] = eoi_valid & (cfg_vector[g*VEC_W +: VEC_W] == eoi_vector);

        idc_pin_track u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw      (pin_level[g]),
            .pol      (cfg_polarity[g]),
            .lvl_trig (cfg_level_trig[g]),
            .mask     (cfg_mask[g]),
            .load     (load_vec[g]),
            .eoi_hit  (eoi_hit[g]),
            .eligible (elig_vec[g]),
            .coal_q   (coalesced[g]),
            .rirr_q   (rirr_vec[g])
        );
    end

    // lowest ready pin wins
    idc_prio_pick #(.N(NPINS), .IW(PIN_W)) u_pick (
        .req (elig_vec),
        .gnt (gnt_vec),
        .idx (sel_idx),
        .any (any_req)
    );

    // load when a request exists and the output slot frees up
    assign take     = any_req & (~msg_valid | msg_ready);
    assign load_vec = gnt_vec & {NPINS{take}};

    // message fields of the winner, pin 0 forced to the boot processor
    assign is_p0       = (sel_idx == '0);
    assign sel_dest    = is_p0 ? BOOT_ID : cfg_dest[int'(sel_idx)*DEST_W +: DEST_W];
    assign sel_logical = is_p0 ? 1'b0 : cfg_logical[sel_idx];
    assign pay_d = {sel_idx,
                    cfg_vector[int'(sel_idx)*VEC_W +: VEC_W],
                    sel_dest,
                    sel_logical,
                    cfg_level_trig[sel_idx],
                    cfg_dmode[int'(sel_idx)*DMODE_W +: DMODE_W]};

    // output holding stage
    idc_msg_reg #(.W(PAY_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (take),
        .ready (msg_ready),
        .din   (pay_d),
        .valid (msg_valid),
        .dout  (pay_q)
    );

    // unpack the held message
    assign {msg_pin, msg_vector, msg_dest, msg_logical, msg_level_trig, msg_dmode} = pay_q;
    assign msg_assert    = 1'b1;
    assign msg_shorthand = '0;
endmodule

// File: rtl/idc_delivery_chk.sv
// Property checker for idc_delivery_ctrl, bound to every instance.
module idc_delivery_chk #(
    parameter int NPINS  = 8,
    parameter int VEC_W  = 8,
    parameter int DEST_W = 8,
    parameter int PIN_W  = 3,
    parameter logic [DEST_W-1:0] BOOT_ID = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [PIN_W-1:0]  msg_pin,
    input logic [VEC_W-1:0]  msg_vector,
    input logic [DEST_W-1:0] msg_dest,
    input logic              msg_logical,
    input logic [NPINS-1:0]  cfg_mask,
    input logic [NPINS-1:0]  cfg_level_trig,
    input logic [NPINS-1:0]  load_vec,
    input logic [NPINS-1:0]  rirr_vec,
    input logic [NPINS-1:0]  eoi_hit
);
    // R12
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !msg_valid);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_pin) && $stable(msg_vector) && $stable(msg_dest));

    // R9
    single_load_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(load_vec));

    // R5
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n) (load_vec & cfg_mask) == '0);

    // R4
    inservice_block_chk: assert property (@(posedge clk) disable iff (!rst_n) (load_vec & rirr_vec) == '0);

    // R8
    boot_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && (msg_pin == '0) |-> (msg_dest == BOOT_ID) && !msg_logical);

    for (genvar g = 0; g < NPINS; g++) begin : g_pin_chk
        // R4
        inservice_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            load_vec[g] && cfg_level_trig[g] |=> rirr_vec[g]);

        // R6
        eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rirr_vec[g] && eoi_hit[g] && !load_vec[g] |=> !rirr_vec[g]);
    end
endmodule

bind idc_delivery_ctrl idc_delivery_chk #(
    .NPINS   (NPINS),
    .VEC_W   (VEC_W),
    .DEST_W  (DEST_W),
    .PIN_W   (PIN_W),
    .BOOT_ID (BOOT_ID)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .msg_valid      (msg_valid),
    .msg_ready      (msg_ready),
    .msg_pin        (msg_pin),
    .msg_vector     (msg_vector),
    .msg_dest       (msg_dest),
    .msg_logical    (msg_logical),
    .cfg_mask       (cfg_mask),
    .cfg_level_trig (cfg_level_trig),
    .load_vec       (load_vec),
    .rirr_vec       (rirr_vec),
    .eoi_hit        (eoi_hit)
);

// File: tb/tb_idc_delivery_ctrl.sv
module tb_idc_delivery_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int VW = 8;
    localparam int DW = 8;
    localparam int PW = 3;
    localparam logic [DW-1:0] BOOT = 8'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] pin_level = '0, cfg_polarity = '0, cfg_level_trig = '0;
    logic [N-1:0] cfg_mask = '1, cfg_logical = '0;
    logic [N*VW-1:0] cfg_vector = '0;
    logic [N*DW-1:0] cfg_dest = '0;
    logic [N*3-1:0]  cfg_dmode = '0;
    logic eoi_valid = 1'b0;
    logic [VW-1:0] eoi_vector = '0;
    logic msg_ready = 1'b0;
    logic msg_valid, msg_logical, msg_level_trig, msg_assert;
    logic [PW-1:0] msg_pin;
    logic [VW-1:0] msg_vector;
    logic [DW-1:0] msg_dest;
    logic [2:0] msg_dmode;
    logic [1:0] msg_shorthand;
    logic [N-1:0] coalesced;

    idc_delivery_ctrl #(.NPINS(N), .VEC_W(VW), .DEST_W(DW), .BOOT_ID(BOOT)) dut (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .cfg_polarity(cfg_polarity),
        .cfg_level_trig(cfg_level_trig), .cfg_mask(cfg_mask), .cfg_logical(cfg_logical),
        .cfg_vector(cfg_vector), .cfg_dest(cfg_dest), .cfg_dmode(cfg_dmode),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_pin(msg_pin), .msg_vector(msg_vector),
        .msg_dest(msg_dest), .msg_logical(msg_logical), .msg_level_trig(msg_level_trig),
        .msg_dmode(msg_dmode), .msg_assert(msg_assert), .msg_shorthand(msg_shorthand),
        .coalesced(coalesced)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int dcnt [N];
    int ccnt [N];
    int order [$];
    bit done = 1'b0;

    // reference model state
    bit m_pend [N];
    bit m_want [N];
    bit m_rirr [N];
    bit m_coal [N];
    bit m_valid;
    int m_pin;
    logic [VW-1:0] m_vec;
    logic [DW-1:0] m_dest;
    bit m_log, m_trig;
    logic [2:0] m_dm;

    task automatic check(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // model step and handshake observation on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_pend[i] = 0; m_want[i] = 0; m_rirr[i] = 0; m_coal[i] = 0;
            end
            m_valid = 0;
        end else begin
            int sel;
            bit ld;
            if (msg_valid && msg_ready) begin
                dcnt[msg_pin]++;
                order.push_back(int'(msg_pin));
                check("R7", "assert flag", msg_assert, 1);
                check("R7", "shorthand", msg_shorthand, 0);
                check("R7", "vector", msg_vector, 8'h20 + msg_pin);
                check("R7", "dmode", msg_dmode, msg_pin);
                if (msg_pin == 0) begin
                    check("R8", "pin0 dest", msg_dest, BOOT);
                    check("R8", "pin0 mode", msg_logical, 0);
                end else begin
                    check("R7", "dest", msg_dest, 8'h10 + msg_pin);
                    check("R7", "mode", msg_logical, msg_pin % 2);
                end
            end
            sel = -1;
            for (int i = 0; i < N; i++) begin
                bit ok;
                ok = !cfg_mask[i] && (cfg_level_trig[i] ? (m_pend[i] && !m_rirr[i]) : m_want[i]);
                if (ok && sel < 0) sel = i;
            end
            ld = (sel >= 0) && (!m_valid || msg_ready);
            for (int i = 0; i < N; i++) begin
                bit eff, rise, li, hit;
                eff  = pin_level[i] ^ cfg_polarity[i];
                rise = eff && !m_pend[i];
                li   = ld && (sel == i);
                hit  = eoi_valid && (cfg_vector[i*VW +: VW] == eoi_vector);
                if (cfg_level_trig[i]) begin
                    m_coal[i] = !cfg_mask[i] && rise && m_rirr[i];
                    m_want[i] = 0;
                    m_rirr[i] = li || (m_rirr[i] && !hit);
                end else begin
                    m_coal[i] = !cfg_mask[i] && rise && m_want[i] && !li;
                    m_want[i] = !cfg_mask[i] && ((m_want[i] && !li) || rise);
                    m_rirr[i] = 0;
                end
                m_pend[i] = eff;
            end
            if (ld) begin
                m_valid = 1;
                m_pin   = sel;
                m_vec   = cfg_vector[sel*VW +: VW];
                m_dest  = (sel == 0) ? BOOT : cfg_dest[sel*DW +: DW];
                m_log   = (sel == 0) ? 1'b0 : cfg_logical[sel];
                m_trig  = cfg_level_trig[sel];
                m_dm    = cfg_dmode[sel*3 +: 3];
            end else if (msg_ready) begin
                m_valid = 0;
            end
        end
    end

    // compare every output away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check("R9", "msg_valid", msg_valid, m_valid);
            for (int i = 0; i < N; i++) begin
                check("R10", "coalesced", coalesced[i], m_coal[i]);
                if (coalesced[i]) ccnt[i]++;
            end
            if (m_valid) begin
                check("R9", "msg_pin", msg_pin, m_pin);
                check("R7", "msg_vector", msg_vector, m_vec);
                check("R8", "msg_dest", msg_dest, m_dest);
                check("R8", "msg_logical", msg_logical, m_log);
                check("R7", "msg_level_trig", msg_level_trig, m_trig);
                check("R7", "msg_dmode", msg_dmode, m_dm);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic set_entry(int i, bit pol, bit lvl, bit msk);
        cfg_polarity[i]   = pol;
        cfg_level_trig[i] = lvl;
        cfg_mask[i]       = msk;
        cfg_vector[i*VW +: VW] = 8'h20 + i[7:0];
        cfg_dest[i*DW +: DW]   = 8'h10 + i[7:0];
        cfg_dmode[i*3 +: 3]    = i[2:0];
        cfg_logical[i]         = (i == 0) ? 1'b1 : i[0];
    endtask

    task automatic send_eoi(logic [VW-1:0] v);
        eoi_valid  = 1'b1;
        eoi_vector = v;
        tick(1);
        eoi_valid  = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            dcnt[i] = 0; ccnt[i] = 0;
            set_entry(i, 0, 0, 1);
        end
        tick(3);
        // R12 reset state
        check("R12", "valid in reset", msg_valid, 0);
        check("R12", "coalesced in reset", coalesced, 0);
        rst_n = 1'b1;
        msg_ready = 1'b1;
        tick(2);
        check("R12", "valid after reset", msg_valid, 0);

        // R3 edge pin, two separate rises, long high hold
        set_entry(2, 0, 0, 0);
        tick(1);
        pin_level[2] = 1; tick(3);
        pin_level[2] = 0; tick(2);
        pin_level[2] = 1; tick(6);
        pin_level[2] = 0;
        check("R3", "edge deliveries pin2", dcnt[2], 2);

        // R1 inverted polarity: falling raw level is a request
        pin_level[3] = 1; tick(1);
        set_entry(3, 1, 0, 0); tick(2);
        pin_level[3] = 0; tick(5);
        check("R1", "inverted deliveries pin3", dcnt[3], 1);

        // R4 R10 R6 R2 level pin with in-service flag
        set_entry(4, 0, 1, 0);
        pin_level[4] = 1; tick(5);
        check("R4", "first level delivery", dcnt[4], 1);
        pin_level[4] = 0; tick(1);
        pin_level[4] = 1; tick(4);
        check("R4", "no delivery while in service", dcnt[4], 1);
        check("R10", "coalesced pulses pin4", ccnt[4], 1);
        send_eoi(8'h33); tick(4);
        check("R6", "non-matching eoi", dcnt[4], 1);
        send_eoi(8'h24); tick(4);
        check("R6", "matching eoi redelivers", dcnt[4], 2);
        pin_level[4] = 0; tick(1);
        send_eoi(8'h24); tick(4);
        check("R2", "low level after eoi", dcnt[4], 2);

        // R5 R11 masked pins
        set_entry(5, 0, 1, 1);
        set_entry(6, 0, 0, 1);
        pin_level[5] = 1;
        pin_level[6] = 1; tick(2);
        pin_level[6] = 0; tick(4);
        check("R5", "masked level", dcnt[5], 0);
        check("R5", "masked edge", dcnt[6], 0);
        cfg_mask[5] = 0; tick(4);
        check("R11", "unmask level pending", dcnt[5], 1);
        cfg_mask[6] = 0; tick(4);
        check("R5", "dropped edge after unmask", dcnt[6], 0);

        // R9 R8 simultaneous requests under back-pressure
        msg_ready = 1'b0;
        set_entry(0, 0, 0, 0);
        set_entry(1, 0, 0, 0);
        set_entry(7, 0, 0, 0);
        tick(1);
        order.delete();
        pin_level[7] = 1; pin_level[1] = 1; pin_level[0] = 1;
        tick(6);
        check("R9", "stalled valid", msg_valid, 1);
        check("R9", "stalled pin", msg_pin, 0);
        check("R8", "stalled pin0 dest", msg_dest, BOOT);
        msg_ready = 1'b1;
        tick(6);
        check("R9", "order count", order.size(), 3);
        if (order.size() == 3) begin
            check("R9", "order first", order[0], 0);
            check("R9", "order second", order[1], 1);
            check("R9", "order third", order[2], 7);
        end
        check("R3", "held edges no repeat", dcnt[0] + dcnt[1] + dcnt[7], 3);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule